// File: doc/BRIEF.md
# Serial Control Port Register Writer

This block is the slave side of a write-only, three-wire serial control port. A host microcontroller drives an active-low select, a bit clock and a data line. The block samples all three in the core clock domain, rebuilds bytes from rising edges of the bit clock and turns each select window into a configuration write. The first byte of a window holds a 7-bit device address and a direction flag. The second byte loads an 8-bit pointer register. Every byte after that is written into the register bank at the index the pointer selects.

The pointer carries an auto-advance flag. When the flag is clear, every data byte in a window lands in one register. When it is set, the pointer moves on after each byte, so one window can fill a run of registers. The contents of the writable registers leave the block as one flat parallel bus. For every byte that is actually stored, the block also gives a one-cycle strobe with the register index, so that downstream logic can react to a fresh setting.

Top module: `spi_ctl_port`

## Requirements
- R1: While the select input `csN` is low, each rising edge of `cclk` shifts one bit of `cdin` into the port, most significant bit first. Eight such edges make one byte.
- R2: The seven most significant bits of the first byte of a window must equal 7'b0010000. Otherwise the window stores nothing and leaves the pointer unchanged.
- R3: Bit 0 of the first byte is the direction flag. A window whose flag is 1 stores nothing and leaves the pointer unchanged.
- R4: The second byte of an accepted window loads `mapReg`. Bit 7 is the auto-advance flag and bits 2:0 are the register index. Bits 6:3 always read back as 0.
- R5: With bit 7 of `mapReg` clear, every data byte of the window goes to the same register and the index stays the same. The last byte written is the value that remains.
- R6: With bit 7 of `mapReg` set, the index advances by one after each data byte. An index of 6 or 7 advances to 0. A data byte aimed at index 6 or 7 is dropped.
- R7: While `rstN` is low, all registers and `mapReg` read 00h. This also holds in the cycle in which reset is released.
- R8: Bits 1:0 of register 1 always read 0, whatever value the host writes to them.
- R9: Each stored byte raises `wrStrobe` for exactly one cycle, with its index on `wrIndex`. In that same cycle the new value is already visible on `cfgRegs`, where register k occupies bits 8k+7:8k.
- R10: If `csN` rises before a byte is complete, the partial byte is discarded. The next window starts again with the device-address byte.
- R11: `cfgRegs` changes only in cycles in which `wrStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all three serial inputs are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select that frames one transfer |
| cclk | input | 1 | Serial bit clock from the host |
| cdin | input | 1 | Serial data from the host |
| cfgRegs | output | 48 | Writable registers 0 to 5, register k in bits 8k+7:8k |
| mapReg | output | 8 | Pointer register: auto-advance flag and index |
| wrStrobe | output | 1 | One-cycle pulse for each stored byte |
| wrIndex | output | 3 | Index of the register stored under `wrStrobe` |

## Verification
Some internal faults show up at the next strobe. A bit counter that drifts, or a phase register stuck in the wrong state, makes `wrStrobe` come with the wrong index or the wrong byte, or go missing altogether. A per-cycle reference catches that in the same cycle as the strobe. A pointer fault can stay hidden while auto-advance is off. It shows up only once a multi-byte window crosses index 5, so wrap-around and the dropped index 6 are driven on purpose. Frames with a wrong address, the read flag set or a cut-off byte must leave `cfgRegs` and `mapReg` bit-for-bit unchanged. These are compared directly after the frame.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_DEV  = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  // Strobes from the frame control into the register datapath
  typedef struct packed {
    logic              ptrLoad;
    logic              dataWrite;
    logic [BYTE_W-1:0] byteVal;
  } ctl_cmd_t;

  // Bits the host may change in register idx; status bits stay zero
  function automatic logic [BYTE_W-1:0] wrMask(input int idx);
    return (idx == 1) ? 8'hFC : 8'hFF;
  endfunction

endpackage

// File: rtl/spi_ctl_ctrl.sv
module spi_ctl_ctrl
  import spi_ctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b0010000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     cclk,
  input  logic     cdin,
  output ctl_cmd_t cmd
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] csPipe, clkPipe, datPipe;
  logic csS, clkS, datS, clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      clkPipe <= '0;
      datPipe <= '0;
      clkPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], cclk};
      datPipe <= {datPipe[SYNC_STAGES-2:0], cdin};
      clkPrev <= clkS;
    end
  end

  assign csS  = csPipe[SYNC_STAGES-1];
  assign clkS = clkPipe[SYNC_STAGES-1];
  assign datS = datPipe[SYNC_STAGES-1];

  logic             bitRise, byteDone;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] shiftNext;
  phase_t           phase;

  always_comb begin
    bitRise   = clkS & ~clkPrev & ~csS;
    shiftNext = {shiftReg, datS};
    byteDone  = bitRise && (bitCnt == CNT_W'(BYTE_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      phase    <= PH_DEV;
    end else if (csS) begin
      bitCnt <= '0;
      phase  <= PH_DEV;
    end else if (bitRise) begin
      shiftReg <= shiftNext[BYTE_W-2:0];
      bitCnt   <= bitCnt + 1'b1;
      if (byteDone) begin
        unique case (phase)
          PH_DEV:  phase <= (shiftNext[7:1] == DEV_ADDR && !shiftNext[0]) ? PH_PTR : PH_SKIP;
          PH_PTR:  phase <= PH_DATA;
          PH_DATA: phase <= PH_DATA;
          default: phase <= PH_SKIP;
        endcase
      end
    end
  end

  always_comb begin
    cmd.ptrLoad   = byteDone && (phase == PH_PTR);
    cmd.dataWrite = byteDone && (phase == PH_DATA);
    cmd.byteVal   = shiftNext;
  end

endmodule

// File: rtl/spi_ctl_regbank.sv
module spi_ctl_regbank
  import spi_ctl_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int RO_INDEX = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_cmd_t                   cmd,
  output logic [NUM_REGS*BYTE_W-1:0] cfgRegs,
  output logic [BYTE_W-1:0]          mapReg,
  output logic                       wrStrobe,
  output logic [2:0]                 wrIndex
);

  localparam int PTR_W = 3;
  localparam int GAP_W = BYTE_W - 1 - PTR_W;

  logic [PTR_W-1:0] ptrIdx, nextPtr;
  logic             autoInc, idxOk;

  always_comb begin
    ptrIdx  = mapReg[PTR_W-1:0];
    autoInc = mapReg[BYTE_W-1];
    idxOk   = ptrIdx < PTR_W'(NUM_REGS);
    nextPtr = (ptrIdx >= PTR_W'(RO_INDEX)) ? '0 : ptrIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapReg <= '0;
    end else if (cmd.ptrLoad) begin
      mapReg <= {cmd.byteVal[BYTE_W-1], {GAP_W{1'b0}}, cmd.byteVal[PTR_W-1:0]};
    end else if (cmd.dataWrite && autoInc) begin
      mapReg[PTR_W-1:0] <= nextPtr;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] MASK = wrMask(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgRegs[g*BYTE_W +: BYTE_W] <= '0;
      end else if (cmd.dataWrite && ptrIdx == PTR_W'(g)) begin
        cfgRegs[g*BYTE_W +: BYTE_W] <= cmd.byteVal & MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
    end else begin
      wrStrobe <= cmd.dataWrite && idxOk;
      wrIndex  <= ptrIdx;
    end
  end

endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter int         RO_INDEX    = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b0010000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  cclk,
  input  logic                  cdin,
  output logic [NUM_REGS*8-1:0] cfgRegs,
  output logic [7:0]            mapReg,
  output logic                  wrStrobe,
  output logic [2:0]            wrIndex
);

  ctl_cmd_t cmd;

  spi_ctl_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ADDR   (DEV_ADDR)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .csN (csN),
    .cclk(cclk),
    .cdin(cdin),
    .cmd (cmd)
  );

  spi_ctl_regbank #(
    .NUM_REGS(NUM_REGS),
    .RO_INDEX(RO_INDEX)
  ) u_bank (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .cfgRegs (cfgRegs),
    .mapReg  (mapReg),
    .wrStrobe(wrStrobe),
    .wrIndex (wrIndex)
  );

endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk #(
  parameter int NUM_REGS = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  csN,
  input logic [NUM_REGS*8-1:0] cfgRegs,
  input logic [7:0]            mapReg,
  input logic                  wrStrobe,
  input logic [2:0]            wrIndex
);

  localparam logic [2:0] IDX_LIM = 3'(NUM_REGS);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rstN) |-> (cfgRegs == '0 && mapReg == '0)); // R7

  AST_MAP_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    mapReg[6:3] == 4'd0); // R4

  AST_STROBE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> wrIndex < IDX_LIM); // R6

  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    cfgRegs[9:8] == 2'b00); // R8

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R9

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> $stable(cfgRegs)); // R11

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4)) |-> !wrStrobe); // R10

endmodule

bind spi_ctl_port spi_ctl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .cfgRegs (cfgRegs),
  .mapReg  (mapReg),
  .wrStrobe(wrStrobe),
  .wrIndex (wrIndex)
);

// File: tb/spi_ctl_port_tb.sv
`timescale 1ns/1ps
module spi_ctl_port_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, cclk = 1'b0, cdin = 1'b0;
  logic [47:0] cfgRegs;
  logic [7:0]  mapReg;
  logic        wrStrobe;
  logic [2:0]  wrIndex;

  always #2.5 clk = ~clk;

  spi_ctl_port u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .cclk(cclk), .cdin(cdin),
    .cfgRegs(cfgRegs), .mapReg(mapReg), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  logic [7:0]  mReg [6];
  logic [7:0]  mMap;
  logic [10:0] expQ [$];
  logic [7:0]  dataBuf [8];
  logic [47:0] prevRegs;
  logic        prevStrobe;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Reference monitor, compared every cycle
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      report();
      $finish;
    end
    if (rstN && !done) begin
      if (wrStrobe) begin
        checks++;
        if (prevStrobe) begin
          failures++;
          $display("FAIL R9: strobe actual=2 cycles expected=1 cycle");
        end
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R9: unexpected strobe idx actual=%0d expected=none", wrIndex);
        end else begin
          logic [10:0] e;
          e = expQ.pop_front();
          if (wrIndex != e[10:8] || cfgRegs[wrIndex*8 +: 8] != e[7:0]) begin
            failures++;
            $display("FAIL R9: idx/data actual=%0d/%h expected=%0d/%h",
                     wrIndex, cfgRegs[wrIndex*8 +: 8], e[10:8], e[7:0]);
          end
        end
      end else if (cfgRegs != prevRegs) begin
        checks++; failures++;
        $display("FAIL R11: regs changed without strobe actual=%h expected=%h", cfgRegs, prevRegs);
      end
    end
    prevRegs   = cfgRegs;
    prevStrobe = wrStrobe;
  end

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      cclk = 1'b0; cdin = b[i];
      waitClk(4);
      cclk = 1'b1;
      waitClk(4);
    end
  endtask

  // Full frame plus reference model update
  task automatic frame(input logic [6:0] dev, input logic rw, input logic [7:0] map,
                       input int nData, input int partial);
    bit ok;
    ok = (dev == 7'b0010000) && !rw;
    csN = 1'b0;
    waitClk(4);
    sendBits({dev, rw}, 8);
    sendBits(map, 8);
    if (ok) mMap = {map[7], 4'b0000, map[2:0]};
    for (int k = 0; k < nData; k++) begin
      if (ok) begin
        logic [2:0] idx;
        logic [7:0] v;
        idx = mMap[2:0];
        v = dataBuf[k] & ((idx == 3'd1) ? 8'hFC : 8'hFF);
        if (idx < 3'd6) begin
          expQ.push_back({idx, v});
          mReg[idx] = v;
        end
        if (mMap[7]) mMap[2:0] = (idx >= 3'd6) ? 3'd0 : idx + 3'd1;
      end
      sendBits(dataBuf[k], 8);
    end
    if (partial > 0) sendBits(8'hFF, partial);
    waitClk(4);
    csN = 1'b1;
    waitClk(10);
  endtask

  task automatic checkAll(input string req);
    for (int r = 0; r < 6; r++) begin
      checks++;
      if (cfgRegs[r*8 +: 8] !== mReg[r]) begin
        failures++;
        $display("FAIL %s: reg%0d actual=%h expected=%h", req, r, cfgRegs[r*8 +: 8], mReg[r]);
      end
    end
    checks++;
    if (mapReg !== mMap) begin
      failures++;
      $display("FAIL %s: mapReg actual=%h expected=%h", req, mapReg, mMap);
    end
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL %s: missing strobes actual=%0d expected=0", req, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic clearModel();
    for (int r = 0; r < 6; r++) mReg[r] = 8'h00;
    mMap = 8'h00;
    expQ.delete();
  endtask

  initial begin
    clearModel();
    waitClk(5);
    // R7: values during reset and after release
    checkAll("R7");
    rstN = 1'b1;
    waitClk(3);
    checkAll("R7");

    // R1 R4: single byte, no advance
    dataBuf[0] = 8'hA5;
    frame(7'b0010000, 1'b0, 8'h02, 1, 0);
    checkAll("R1");

    // R5: three bytes to one register
    dataBuf[0] = 8'h11; dataBuf[1] = 8'h22; dataBuf[2] = 8'h3C;
    frame(7'b0010000, 1'b0, 8'h03, 3, 0);
    checkAll("R5");

    // R6 R8: advance over 0..5, register 1 status bits masked
    for (int k = 0; k < 6; k++) dataBuf[k] = 8'h5F + 8'(k * 17);
    dataBuf[1] = 8'hFF;
    frame(7'b0010000, 1'b0, 8'h80, 6, 0);
    checkAll("R8");

    // R6: from 4, past dropped index 6, wrap to 0
    dataBuf[0] = 8'h44; dataBuf[1] = 8'h55; dataBuf[2] = 8'h66; dataBuf[3] = 8'h77;
    frame(7'b0010000, 1'b0, 8'h84, 4, 0);
    checkAll("R6");

    // R2: wrong device address
    dataBuf[0] = 8'h99; dataBuf[1] = 8'h98;
    frame(7'b0010001, 1'b0, 8'h81, 2, 0);
    checkAll("R2");
    frame(7'b1010000, 1'b0, 8'h02, 1, 0);
    checkAll("R2");

    // R3: read flag set
    frame(7'b0010000, 1'b1, 8'h05, 2, 0);
    checkAll("R3");

    // R4: gap bits in pointer byte forced to zero
    frame(7'b0010000, 1'b0, 8'h7D, 0, 0);
    checkAll("R4");

    // R10: partial byte discarded, next frame decoded normally
    dataBuf[0] = 8'hC3;
    frame(7'b0010000, 1'b0, 8'h05, 1, 5);
    checkAll("R10");
    frame(7'b0010000, 1'b0, 8'h01, 0, 3);
    checkAll("R10");
    dataBuf[0] = 8'h0E;
    frame(7'b0010000, 1'b0, 8'h00, 1, 0);
    checkAll("R10");

    // R6: index 7 and 6 dropped without advance
    dataBuf[0] = 8'hEE;
    frame(7'b0010000, 1'b0, 8'h07, 1, 0);
    checkAll("R6");
    frame(7'b0010000, 1'b0, 8'h06, 1, 0);
    checkAll("R6");

    // R7: reset in the middle of use
    rstN = 1'b0;
    waitClk(3);
    clearModel();
    checkAll("R7");
    rstN = 1'b1;
    waitClk(3);
    checkAll("R7");

    done = 1;
    report();
    $finish;
  end

endmodule